// File: doc/BRIEF.md
# Parallel-to-serial shift register with selectable load timing

This block holds a chain of `N` single-bit stages (eight by default). A byte offered on the parallel inputs can be captured into all stages at once, then clocked out one bit per rising edge while a serial input fills the chain from the other end. With the mode input low the chain is a plain serial-in, serial-out delay line. The last three stages are visible, so a consumer can use one, two or three bits of lookahead on the outgoing stream.

A build-time parameter selects how the parallel capture happens. With `ASYNC_LOAD = 0` the capture takes place on a rising clock edge sampled with the mode input high. With `ASYNC_LOAD = 1` the mode input alone performs the capture: while it is high the stages follow the parallel inputs with no clock, and the clock is ignored. When it drops, the last value presented stays until the next rising edge. Shifting is clocked in both builds. There is no reset, so the contents are undefined until the first load, and every stage keeps its value indefinitely while the clock is stopped.

Top module: `shreg_piso`

## Requirements
- R1: With `ASYNC_LOAD = 0`, a rising clock edge with `load_sel` = 1 writes `par_in[k-1]` into stage k for every k from 1 to N.
- R2: With `ASYNC_LOAD = 0`, raising `load_sel` or changing `par_in` between clock edges leaves the outputs unchanged until the next rising edge.
- R3: In both builds, a rising edge with `load_sel` = 0 writes `ser_in` into stage 1 and the old value of stage k-1 into stage k for k from 2 to N. The old value of stage N is discarded.
- R4: `tap_n` shows stage N, `tap_n1` shows stage N-1 and `tap_n2` shows stage N-2.
- R5: With `ASYNC_LOAD = 1`, while `load_sel` = 1 the stages follow `par_in` continuously, and a change of `par_in` appears on the outputs with no clock edge.
- R6: With `ASYNC_LOAD = 1`, rising clock edges while `load_sel` = 1 do not shift. The stages keep showing `par_in`.
- R7: With `ASYNC_LOAD = 1`, when `load_sel` falls the stages keep the `par_in` value present at that moment. Later changes of `par_in` have no effect until the next rising edge shifts.
- R8: With the clock stopped and `load_sel` = 0, the contents hold for any length of time, whatever `ser_in` and `par_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| load_sel | input | 1 | 1 = parallel load, 0 = serial shift |
| ser_in | input | 1 | Serial data entering stage 1 |
| par_in | input | N | Parallel data, bit k-1 feeds stage k |
| tap_n2 | output | 1 | Content of stage N-2 |
| tap_n1 | output | 1 | Content of stage N-1 |
| tap_n | output | 1 | Content of stage N |

## Verification
Two functions meet when the mode input and a clock edge act together. In the clocked build, a load and a shift compete for the same edge. In the other build, a live load overlaps clock edges that must be ignored, and a load can release shortly before the edge that starts shifting. The bench provokes each case in both builds at once from shared stimulus. It changes `par_in` and `load_sel` between edges, holds the load across several edges, and drops it just before an edge. It judges the taps against two reference models updated only from the requirements, sampling both just after the edge and mid-cycle.

// File: rtl/shreg_piso.sv
`timescale 1ns/1ps
module shreg_piso #(
  parameter int N          = 8,
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic         clk,
  input  logic         load_sel,
  input  logic         ser_in,
  input  logic [N-1:0] par_in,
  output logic         tap_n2,
  output logic         tap_n1,
  output logic         tap_n
);
  localparam int TOP = N - 1;

  logic [TOP:0] cur;

  generate
    if (ASYNC_LOAD == 1'b0) begin : g_sync
      logic [TOP:0] sh;
      always_ff @(posedge clk)
        sh <= load_sel ? par_in : {sh[TOP-1:0], ser_in};
      assign cur = sh;

      a_r1_sync_load: assert property (@(posedge clk)
        load_sel |=> cur == $past(par_in));
      a_r3_shift: assert property (@(posedge clk)
        !load_sel |=> cur == {$past(cur[TOP-1:0]), $past(ser_in)});
      a_r3_stage1: assert property (@(posedge clk)
        !load_sel |=> cur[0] == $past(ser_in));
    end else begin : g_async
      logic [TOP:0] sh;
      logic [TOP:0] lat;
      logic         from_lat;

      always_latch
        if (load_sel) lat = par_in;

      always_ff @(posedge clk or posedge load_sel)
        if (load_sel) from_lat <= 1'b1;
        else          from_lat <= 1'b0;

      always_ff @(posedge clk)
        if (!load_sel) sh <= {cur[TOP-1:0], ser_in};

      assign cur = from_lat ? lat : sh;

      a_r5_follow: assert property (@(posedge clk)
        load_sel |-> cur == par_in);
      a_r6_no_shift: assert property (@(posedge clk)
        load_sel && $past(load_sel) |-> cur == $past(par_in) || cur == par_in);
    end
  endgenerate

  assign tap_n  = cur[TOP];
  assign tap_n1 = cur[TOP-1];
  assign tap_n2 = cur[TOP-2];
endmodule

// File: tb/test_shreg_piso.sv
`timescale 1ns/1ps
module test_shreg_piso;
  logic       clk = 1'b0;
  logic       run = 1'b1;
  logic       load_sel = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       s2, s1, s0, a2, a1, a0;
  logic [7:0] m_s, m_a;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  initial forever begin
    #2;
    if (run) clk = ~clk;
  end

  shreg_piso #(.N(8), .ASYNC_LOAD(1'b0)) i_shreg_piso (
    .clk(clk), .load_sel(load_sel), .ser_in(ser_in), .par_in(par_in),
    .tap_n2(s2), .tap_n1(s1), .tap_n(s0));

  shreg_piso #(.N(8), .ASYNC_LOAD(1'b1)) i_shreg_piso_async (
    .clk(clk), .load_sel(load_sel), .ser_in(ser_in), .par_in(par_in),
    .tap_n2(a2), .tap_n1(a1), .tap_n(a0));

  // fields: [9] load_sel, [8:1] par_in, [0] ser_in
  localparam logic [9:0] VEC [20] = '{
    {1'b1, 8'hA5, 1'b0}, {1'b0, 8'h00, 1'b1}, {1'b0, 8'hFF, 1'b0},
    {1'b0, 8'h12, 1'b1}, {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b0}, {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b1},
    {1'b1, 8'h6E, 1'b1}, {1'b1, 8'h81, 1'b0}, {1'b0, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b0}, {1'b0, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b0}, {1'b0, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b1}, {1'b1, 8'h5C, 1'b0}
  };

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: taps %b, expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic both(input string req);
    chk({req, " sync"},  {s0, s1, s2}, {m_s[7], m_s[6], m_s[5]});
    chk({req, " async"}, {a0, a1, a2}, {m_a[7], m_a[6], m_a[5]});
  endtask

  task automatic edge_step();
    @(posedge clk);
    m_s = load_sel ? par_in : {m_s[6:0], ser_in};
    m_a = load_sel ? par_in : {m_a[6:0], ser_in};
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_s = 8'h00;
    m_a = 8'h00;
    // R1 R3 R4 R6: table of loads and shifts, both builds
    foreach (VEC[i]) begin
      @(negedge clk);
      {load_sel, par_in, ser_in} = VEC[i];
      edge_step();
      both("R1/R3/R4 table");
    end

    // R2: new load pending in sync build, nothing moves before the edge
    @(negedge clk);
    load_sel = 1'b0; ser_in = 1'b1;
    edge_step();
    @(negedge clk);
    load_sel = 1'b1; par_in = 8'h3C;
    #0.5;
    chk("R2 sync pending", {s0, s1, s2}, {m_s[7], m_s[6], m_s[5]});
    chk("R5 async follow", {a0, a1, a2}, 3'b001);
    edge_step();
    both("R1 load on edge");

    // R6: clocks while load held high
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ser_in = ~ser_in;
      edge_step();
      both("R6 load held");
    end

    // R5 R7: change par mid-cycle, drop load, change par again
    @(negedge clk);
    par_in = 8'hC3;
    #0.3;
    chk("R5 async follow", {a0, a1, a2}, 3'b110);
    chk("R2 sync ignores par", {s0, s1, s2}, 3'b001);
    par_in = 8'h99;
    #0.2;
    load_sel = 1'b0;
    #0.2;
    par_in = 8'hFF;
    ser_in = 1'b0;
    #0.3;
    chk("R7 async held", {a0, a1, a2}, 3'b100);
    m_a = 8'h99;
    @(posedge clk);
    m_s = {m_s[6:0], ser_in};
    m_a = {m_a[6:0], ser_in};
    #1;
    both("R7 shift after release");

    // R8: clock stopped, inputs wiggle with load low
    @(negedge clk);
    run = 1'b0;
    #1;
    for (int k = 0; k < 20; k++) begin
      ser_in = ~ser_in;
      par_in = par_in ^ 8'h5A;
      #10;
    end
    both("R8 static hold");
    run = 1'b1;

    // R3 R4: load then shift a full byte out, watching every tap
    @(negedge clk);
    load_sel = 1'b1; par_in = 8'hB2;
    edge_step();
    both("R1 load B2");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      load_sel = 1'b0;
      ser_in = k[0] ^ k[2];
      edge_step();
      both("R3/R4 shift out");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule